// File: doc/BRIEF.md
# Component Video Line Formatter for an 8-bit Output Port

This block turns a stream of pre-processed 4:2:2 component samples into the byte sequence of an 8-bit parallel video port. Each line starts with an end-of-active-video timing code and continues with a horizontal blanking interval filled with an alternating blanking pattern. A start-of-active-video code follows, and then the 720 active pixels, interleaved as chroma-blue, luma, chroma-red, luma. The line length in bytes is an input, and a pixel-rate enable paces the whole block.

A per-line type code chooses between processed component video, test-line video and raw composite samples placed in the luma slots. A 4-bit mode input chooses one of several output forms. In 10-bit output the two low bits go out on two side pins. Code suppression removes the timing codes and the blanking pattern. Converter bypass puts raw converter words on the bus with no line structure at all. The field and vertical-blanking flags carried in the status words change only at the start of a line.

Top module: `vpf_out_fmt`

## Requirements
- R1: After reset the line begins with the end code. The end code takes 4 bytes, blanking takes `line_total` minus 1448 bytes, the start code takes 4 bytes and active video takes 1440 bytes. Active byte k (k from 0) carries `cb_in` when k mod 4 is 0, `cr_in` when k mod 4 is 2, and the luma input on odd k. Line types 0, 14 and 15 use `y_in` for luma.
- R2: Each timing code is FF, 00, 00, then a status byte {1, F, V, H, V^H, F^H, F^V, F^V^H} (MSB first). H is 1 in the end code and 0 in the start code.
- R3: Blanking bytes alternate 80, 10, and the first blanking byte after the end code is 80.
- R4: F, V and the line type are captured only on the enabled cycle that emits the first byte of the end code; changes at any other time act from the next line. With `mode[0]`=0, V follows `vblank_in`. With `mode[0]`=1, V is `vblank_in` OR (line type in 1..13).
- R5: Every 10-bit active sample is clamped to 4..1019 before output, so active bus bytes are always within 01..FE.
- R6: For line types 1 to 13, the luma slots carry `cvbs_in` and the chroma slots are unchanged.
- R7: When `mode[2]`=1 and `mode` is not 111x, the bus carries sample bits 9..2, `xd_b1` carries bit 1 and `xd_b0` carries bit 0. Outside active video, and in every other non-bypass mode, both side pins are 0.
- R8: When `mode[2:0]`=010 and `mode` is not 111x, every non-active byte is 00 and active bytes are as in R1/R6.
- R9: When `mode`=1110 (`adc_a`) or 1111 (`adc_b`), every byte is converter bits 8..1 and `xd_b1` is bit 0. `xd_b0` is 0, and no codes or fill are sent, whatever the line type.
- R10: On cycles with `pix_en`=0, the outputs and the line position hold.
- R11: While `rst_n` is low, `xd` is 00 and both side pins are 0. The first enabled byte after reset is the FF of an end code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Byte-rate enable |
| line_total | input | 12 | Total bytes per line (even, at least 1450) |
| mode | input | 4 | Output mode field |
| line_type | input | 4 | Data type of the next line |
| field_in | input | 1 | Field flag for the next line |
| vblank_in | input | 1 | Vertical blanking flag for the next line |
| cb_in | input | 10 | Processed blue-difference sample |
| cr_in | input | 10 | Processed red-difference sample |
| y_in | input | 10 | Processed luma sample |
| cvbs_in | input | 10 | Raw composite sample |
| adc_a | input | 9 | First converter word |
| adc_b | input | 9 | Second converter word |
| xd | output | 8 | Port data bus |
| xd_b1 | output | 1 | Side pin: bit 1 (converter LSB in bypass) |
| xd_b0 | output | 1 | Side pin: bit 0 |

## Verification
The main formatter runs over two full lines per case with sample ramps that sweep the whole 10-bit range. Each ramp has its own step, so the bytes show whether the Cb, Cr, Y and composite slots are placed in the right order and whether the clamp bites at both ends. The type and flags change just after each end code, and the first and second lines use different values. This separates capture at the line start from capture anywhere else, and shows whether the status byte protection bits and both V methods follow. Each output mode (8-bit, 10-bit split, suppressed, both bypass sources) and a case with a pixel enable that drops every third cycle get their own runs. A reset asserted mid-line is also tested.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  typedef enum logic [1:0] {
    ST_EAV   = 2'd0,
    ST_BLANK = 2'd1,
    ST_SAV   = 2'd2,
    ST_ACT   = 2'd3
  } vpf_state_t;

  // Status byte of a timing code with its protection bits
  function automatic logic [7:0] vpf_status(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // Line types 1..13 carry raw composite in the luma slots
  function automatic logic vpf_is_raw(input logic [3:0] t);
    return (t != 4'd0) && (t < 4'd14);
  endfunction

endpackage

// File: rtl/vpf_line_timer.sv
module vpf_line_timer
  import vpf_pkg::*;
#(
  parameter int CW        = 12,
  parameter int ACT_BYTES = 1440
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [CW-1:0] line_total,
  output vpf_state_t    st,
  output logic [CW-1:0] cnt
);

  localparam int          OVERHEAD = ACT_BYTES + 8;
  localparam logic [CW-1:0] ACT_LAST = CW'(ACT_BYTES - 1);
  localparam logic [CW-1:0] CODE_LAST = CW'(3);

  vpf_state_t    st_q, st_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW-1:0] blank_last;

  assign blank_last = line_total - CW'(OVERHEAD) - CW'(1);

  always_comb begin
    st_nx  = st_q;
    cnt_nx = cnt_q + CW'(1);
    unique case (st_q)
      ST_EAV: begin
        if (cnt_q == CODE_LAST) begin
          st_nx  = ST_BLANK;
          cnt_nx = '0;
        end
      end
      ST_BLANK: begin
        if (cnt_q == blank_last) begin
          st_nx  = ST_SAV;
          cnt_nx = '0;
        end
      end
      ST_SAV: begin
        if (cnt_q == CODE_LAST) begin
          st_nx  = ST_ACT;
          cnt_nx = '0;
        end
      end
      default: begin
        if (cnt_q == ACT_LAST) begin
          st_nx  = ST_EAV;
          cnt_nx = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_EAV;
      cnt_q <= '0;
    end else if (pix_en) begin
      st_q  <= st_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign st  = st_q;
  assign cnt = cnt_q;

endmodule

// File: rtl/vpf_code_gen.sv
module vpf_code_gen
  import vpf_pkg::*;
(
  input  vpf_state_t  st,
  input  logic [1:0]  sub,
  input  logic        f,
  input  logic        v,
  output logic [7:0]  code
);

  always_comb begin
    code = 8'h00;
    unique case (st)
      ST_EAV, ST_SAV: begin
        unique case (sub)
          2'd0:    code = 8'hFF;
          2'd3:    code = vpf_status(f, v, st == ST_EAV);
          default: code = 8'h00;
        endcase
      end
      ST_BLANK: code = sub[0] ? 8'h10 : 8'h80;
      default:  code = 8'h00;
    endcase
  end

endmodule

// File: rtl/vpf_sample_mux.sv
module vpf_sample_mux #(
  parameter int DW = 10
) (
  input  logic [1:0]    phase,
  input  logic          raw,
  input  logic [DW-1:0] cb,
  input  logic [DW-1:0] cr,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] cvbs,
  output logic [DW-1:0] samp
);

  localparam logic [DW-1:0] LO = DW'(1 << (DW - 8));
  localparam logic [DW-1:0] HI = DW'((1 << DW) - 1 - (1 << (DW - 8)));

  logic [DW-1:0] pick;

  always_comb begin
    unique case (phase)
      2'd0:    pick = cb;
      2'd2:    pick = cr;
      default: pick = raw ? cvbs : y;
    endcase
  end

  always_comb begin
    if (pick < LO)      samp = LO;
    else if (pick > HI) samp = HI;
    else                samp = pick;
  end

endmodule

// File: rtl/vpf_out_fmt.sv
module vpf_out_fmt
  import vpf_pkg::*;
#(
  parameter int ACT_PIX = 720,
  parameter int DW      = 10,
  parameter int AW      = 9,
  parameter int CW      = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [CW-1:0] line_total,
  input  logic [3:0]    mode,
  input  logic [3:0]    line_type,
  input  logic          field_in,
  input  logic          vblank_in,
  input  logic [DW-1:0] cb_in,
  input  logic [DW-1:0] cr_in,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] cvbs_in,
  input  logic [AW-1:0] adc_a,
  input  logic [AW-1:0] adc_b,
  output logic [7:0]    xd,
  output logic          xd_b1,
  output logic          xd_b0
);

  localparam int ACT_BYTES = 2 * ACT_PIX;

  vpf_state_t    st;
  logic [CW-1:0] cnt;
  logic          line_start;
  logic          f_q, v_q, raw_q;
  logic          byp, supp, ten;
  logic [7:0]    code;
  logic [DW-1:0] samp;
  logic [AW-1:0] adc_sel;
  logic [7:0]    d_nx;
  logic          b1_nx, b0_nx;
  logic [7:0]    d_q;
  logic          b1_q, b0_q;

  // Mode decode
  assign byp  = (mode[3:1] == 3'b111);
  assign supp = !byp && (mode[2:0] == 3'b010);
  assign ten  = !byp && mode[2];

  vpf_line_timer #(.CW(CW), .ACT_BYTES(ACT_BYTES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .line_total (line_total),
    .st         (st),
    .cnt        (cnt)
  );

  assign line_start = pix_en && (st == ST_EAV) && (cnt == '0);

  // Per-line capture of flags and type
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q   <= 1'b0;
      v_q   <= 1'b0;
      raw_q <= 1'b0;
    end else if (line_start) begin
      f_q   <= field_in;
      v_q   <= vblank_in | (mode[0] & vpf_is_raw(line_type));
      raw_q <= vpf_is_raw(line_type);
    end
  end

  vpf_code_gen u_code (
    .st   (st),
    .sub  (cnt[1:0]),
    .f    (f_q),
    .v    (v_q),
    .code (code)
  );

  vpf_sample_mux #(.DW(DW)) u_mux (
    .phase (cnt[1:0]),
    .raw   (raw_q),
    .cb    (cb_in),
    .cr    (cr_in),
    .y     (y_in),
    .cvbs  (cvbs_in),
    .samp  (samp)
  );

  assign adc_sel = mode[0] ? adc_b : adc_a;

  always_comb begin
    d_nx  = code;
    b1_nx = 1'b0;
    b0_nx = 1'b0;
    if (byp) begin
      d_nx  = adc_sel[AW-1 -: 8];
      b1_nx = adc_sel[0];
    end else if (st == ST_ACT) begin
      d_nx  = samp[DW-1 -: 8];
      b1_nx = ten & samp[1];
      b0_nx = ten & samp[0];
    end else if (supp) begin
      d_nx  = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q  <= 8'h00;
      b1_q <= 1'b0;
      b0_q <= 1'b0;
    end else if (pix_en) begin
      d_q  <= d_nx;
      b1_q <= b1_nx;
      b0_q <= b0_nx;
    end
  end

  assign xd    = d_q;
  assign xd_b1 = b1_q;
  assign xd_b0 = b0_q;

endmodule

// File: rtl/vpf_out_fmt_chk.sv
module vpf_out_fmt_chk
  import vpf_pkg::*;
#(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic [3:0]    mode,
  input vpf_state_t    st,
  input logic [CW-1:0] cnt,
  input logic          f_q,
  input logic          v_q,
  input logic [7:0]    xd,
  input logic          xd_b1,
  input logic          xd_b0
);

  logic byp, supp;
  assign byp  = (mode[3:1] == 3'b111);
  assign supp = !byp && (mode[2:0] == 3'b010);

  // R2: end code opens with FF
  a_r2_preamble_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && st == ST_EAV && cnt == '0 && !byp && !supp) |=> (xd == 8'hFF));

  // R3: blanking carries only the fill pair
  a_r3_fill_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && st == ST_BLANK && !byp && !supp) |=> (xd == 8'h80 || xd == 8'h10));

  // R4: flags move only at a line start
  a_r4_flags_at_eav: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_en && st == ST_EAV && cnt == '0) |=> ($stable(f_q) && $stable(v_q)));

  // R5: active bytes never hit reserved values
  a_r5_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && st == ST_ACT && !byp) |=> (xd != 8'h00 && xd != 8'hFF));

  // R7: side pins quiet outside active video
  a_r7_sides_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && st != ST_ACT && !byp) |=> (!xd_b1 && !xd_b0));

  // R9: bypass keeps bit-0 pin low
  a_r9_bypass_b0: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && byp) |=> !xd_b0);

  // R10: outputs hold without enable
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(xd) && $stable(xd_b1) && $stable(xd_b0)));

endmodule

bind vpf_out_fmt vpf_out_fmt_chk #(.CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pix_en (pix_en),
  .mode   (mode),
  .st     (st),
  .cnt    (cnt),
  .f_q    (f_q),
  .v_q    (v_q),
  .xd     (xd),
  .xd_b1  (xd_b1),
  .xd_b0  (xd_b0)
);

// File: tb/vpf_out_fmt_tb_top.sv
`timescale 1ns/1ps
module vpf_out_fmt_tb_top;

  localparam int T    = 1716;
  localparam int SAVP = T - 1444;
  localparam int NC   = 11;

  // {stall, mode, t0, f0, v0, t1, f1, v1}
  localparam logic [16:0] CASES [NC] = '{
    {1'b0, 4'b0000, 4'd0,  1'b0, 1'b0, 4'd5,  1'b1, 1'b0},
    {1'b0, 4'b0000, 4'd14, 1'b1, 1'b1, 4'd15, 1'b0, 1'b0},
    {1'b0, 4'b0001, 4'd3,  1'b0, 1'b0, 4'd0,  1'b1, 1'b0},
    {1'b0, 4'b0011, 4'd13, 1'b1, 1'b0, 4'd14, 1'b0, 1'b1},
    {1'b0, 4'b0100, 4'd0,  1'b0, 1'b1, 4'd13, 1'b1, 1'b1},
    {1'b0, 4'b0111, 4'd7,  1'b1, 1'b0, 4'd0,  1'b0, 1'b0},
    {1'b0, 4'b0010, 4'd0,  1'b0, 1'b0, 4'd2,  1'b1, 1'b1},
    {1'b0, 4'b1010, 4'd9,  1'b1, 1'b0, 4'd0,  1'b0, 1'b0},
    {1'b0, 4'b1110, 4'd0,  1'b0, 1'b0, 4'd5,  1'b1, 1'b1},
    {1'b0, 4'b1111, 4'd14, 1'b1, 1'b1, 4'd3,  1'b0, 1'b0},
    {1'b1, 4'b0000, 4'd6,  1'b0, 1'b0, 4'd0,  1'b1, 1'b1}
  };

  logic       clk, rst_n, pix_en;
  logic [11:0] line_total;
  logic [3:0] mode, line_type;
  logic       field_in, vblank_in;
  logic [9:0] cb_in, cr_in, y_in, cvbs_in;
  logic [8:0] adc_a, adc_b;
  logic [7:0] xd;
  logic       xd_b1, xd_b0;

  int checks, errors;
  bit done;

  logic [3:0] lt0, lt1;
  logic       lf0, lv0, lf1, lv1;

  vpf_out_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_total(line_total),
    .mode(mode), .line_type(line_type), .field_in(field_in), .vblank_in(vblank_in),
    .cb_in(cb_in), .cr_in(cr_in), .y_in(y_in), .cvbs_in(cvbs_in),
    .adc_a(adc_a), .adc_b(adc_b), .xd(xd), .xd_b1(xd_b1), .xd_b0(xd_b0)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [9:0] pv(input int n, input int mul, input int add);
    return 10'((n * mul + add) % 1024);
  endfunction

  function automatic logic [7:0] stw(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [9:0] clampv(input logic [9:0] s);
    if (s < 10'd4) return 10'd4;
    if (s > 10'd1019) return 10'd1019;
    return s;
  endfunction

  task automatic drive(input int n);
    cb_in   = pv(n, 13, 5);
    cr_in   = pv(n, 29, 900);
    y_in    = pv(n, 7, 0);
    cvbs_in = pv(n, 3, 1000);
    adc_a   = 9'(n % 512);
    adc_b   = 9'((n * 5 + 3) % 512);
    line_type = (n < 10) ? lt0 : lt1;
    field_in  = (n < 10) ? lf0 : lf1;
    vblank_in = (n < 10) ? lv0 : lv1;
  endtask

  task automatic expect_at(input int n, input logic [3:0] md,
                           output logic [7:0] d, output logic b1, output logic b0,
                           output string tag);
    int p, ln, k, idx;
    logic [3:0] t;
    logic f, v, raw, byp, supp, ten;
    logic [9:0] s;
    logic [8:0] a;
    byp  = (md[3:1] == 3'b111);
    supp = !byp && (md[2:0] == 3'b010);
    ten  = !byp && md[2];
    d = 8'h00; b1 = 1'b0; b0 = 1'b0;
    if (byp) begin
      a = md[0] ? 9'((n * 5 + 3) % 512) : 9'(n % 512);
      d = a[8:1]; b1 = a[0]; tag = "R9";
      return;
    end
    p  = n % T;
    ln = n / T;
    t  = (ln == 0) ? lt0 : lt1;
    f  = (ln == 0) ? lf0 : lf1;
    raw = (t != 4'd0) && (t < 4'd14);
    v  = ((ln == 0) ? lv0 : lv1) | (md[0] & raw);
    if (p < 4 || (p >= SAVP && p < SAVP + 4)) begin
      k = (p < 4) ? p : p - SAVP;
      if (supp) begin
        d = 8'h00; tag = "R8";
      end else begin
        d = (k == 0) ? 8'hFF : (k < 3) ? 8'h00 : stw(f, v, p < 4);
        tag = (k == 3) ? "R2/R4" : "R2";
      end
    end else if (p < SAVP) begin
      if (supp) begin d = 8'h00; tag = "R8"; end
      else begin d = (((p - 4) % 2) == 0) ? 8'h80 : 8'h10; tag = "R3"; end
    end else begin
      idx = p - SAVP - 4;
      case (idx % 4)
        0: s = pv(n, 13, 5);
        2: s = pv(n, 29, 900);
        default: s = raw ? pv(n, 3, 1000) : pv(n, 7, 0);
      endcase
      s = clampv(s);
      d = s[9:2];
      if (ten) begin b1 = s[1]; b0 = s[0]; end
      tag = ten ? "R7" : raw ? "R6" : "R1/R5";
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] ed, input logic eb1, input logic eb0);
    checks++;
    if (xd !== ed || xd_b1 !== eb1 || xd_b0 !== eb0) begin
      errors++;
      $display("FAIL %s: got xd=%h b1=%b b0=%b expected xd=%h b1=%b b0=%b",
               tag, xd, xd_b1, xd_b0, ed, eb1, eb0);
    end
  endtask

  task automatic run_case(input logic [16:0] cv);
    logic stall;
    logic [3:0] md;
    logic [7:0] ed, pd;
    logic eb1, eb0, pb1, pb0;
    string tag;
    int n, c;
    stall = cv[16];
    md    = cv[15:12];
    lt0 = cv[11:8]; lf0 = cv[7]; lv0 = cv[6];
    lt1 = cv[5:2];  lf1 = cv[1]; lv1 = cv[0];
    @(negedge clk);
    rst_n = 1'b0; pix_en = 1'b0; mode = md;
    drive(0);
    repeat (2) @(negedge clk);
    chk("R11", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    pd = 8'h00; pb1 = 1'b0; pb0 = 1'b0;
    n = 0; c = 0;
    while (n < 2 * T) begin
      pix_en = stall ? ((c % 3) != 1) : 1'b1;
      drive(n);
      if (pix_en) begin
        expect_at(n, md, ed, eb1, eb0, tag);
        n++;
      end else begin
        ed = pd; eb1 = pb1; eb0 = pb0; tag = "R10";
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag, ed, eb1, eb0);
      pd = ed; pb1 = eb1; pb0 = eb0;
      c++;
    end
    pix_en = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; pix_en = 1'b0; line_total = 12'(T);
    mode = 4'b0000; lt0 = 4'd0; lt1 = 4'd0;
    lf0 = 1'b0; lv0 = 1'b0; lf1 = 1'b0; lv1 = 1'b0;
    drive(0);
    for (int i = 0; i < NC; i++) run_case(CASES[i]);

    // Directed: reset asserted in the middle of active video (R11)
    lt0 = 4'd0; lt1 = 4'd0; lf0 = 1'b1; lv0 = 1'b0; lf1 = 1'b1; lv1 = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; mode = 4'b0000;
    @(negedge clk);
    rst_n = 1'b1; pix_en = 1'b1;
    for (int i = 0; i < 600; i++) begin
      drive(i);
      @(negedge clk);
    end
    #1 rst_n = 1'b0;
    #1 chk("R11", 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", 8'hFF, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R11", stw(1'b1, 1'b0, 1'b1), 1'b0, 1'b0);
    pix_en = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule